// File: doc/BRIEF.md
# Legacy Device Activity Status Register

This block keeps a small record of system activity for legacy power management. Hardware sets sticky status flags when it sees activity: an I/O read or write cycle to either keyboard controller port (60h or 64h), or one of eight active-low PCI interrupt request lines being asserted. The eight lines are grouped into four pairs, and each pair drives one flag. Software polls the status register from time to time and acknowledges flags by writing 1 to them. A one-bit scratchpad control register sits beside it.

Both registers are decoded relative to a power-management I/O base that software programs and that arrives on an input. The status register sits at base + 44h and the control register at base + 50h. Reads are combinational and have no side effects. Writes and hardware events take effect at the next rising clock edge.

Top module: `pm_activity_regs`

## Requirements
- R1: While `rst` is high at a clock edge, both registers return to zero: a read of base+44h returns 0000h and a read of base+50h returns 0000h.
- R2: An I/O cycle with `io_rd` or `io_wr` high and `io_addr` equal to 0060h or 0064h sets status bit 12. The bit is visible on the first read after that edge.
- R3: An I/O cycle to any other address (for example 0061h, 0063h, 0065h or 1060h) leaves status bit 12 unchanged. An address that matches with neither `io_rd` nor `io_wr` high also leaves it unchanged.
- R4: Interrupt lines are indexed 0..7 (A..H) in `irq_n`. A line counts as active when it is sampled low at a clock edge. Status bit 6+k (k = 0..3) sets when line k or line k+4 is low.
- R5: A status bit that is set stays set until software clears it.
- R6: A write to base+44h clears each status bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R7: When a hardware event and a write-1-clear hit the same status bit at the same edge, the bit ends up set.
- R8: Status bits 15:13, 11:10 and 5:0 always read 0 and ignore writes.
- R9: A write to base+50h stores `reg_wdata[0]` in the scratchpad bit. A read returns it in `reg_rdata[0]`, and bits 15:1 read 0.
- R10: `reg_rdata` is 0 whenever `reg_rd` is low, and for a read at any other offset. A write to any other offset changes nothing.
- R11: Decoding follows `pm_base`. After the base changes, the registers answer only at the new base+44h and base+50h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_base | input | 16 | Power-management I/O base address |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Register read data (combinational) |
| io_addr | input | 16 | Address of the observed I/O cycle |
| io_rd | input | 1 | Observed I/O read cycle |
| io_wr | input | 1 | Observed I/O write cycle |
| irq_n | input | 8 | Active-low interrupt request lines A..H |

## Verification
The only internal state is the status flags and the scratchpad bit, and every read puts them directly on `reg_rdata`. A missed event, a lost flag, a wrong pairing or a clear that fails to take effect therefore shows up on the first read after the edge where it happened. The bench reads the registers on nearly every cycle and compares the result with a behavioural model. Most faults are caught within one or two cycles of the stimulus that exposes them.

// File: rtl/pm_act_pkg.sv
package pm_act_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int IRQ_PAIRS = 4;
    localparam int IRQ_LINES = 2 * IRQ_PAIRS;

    localparam logic [ADDR_W-1:0] STS_OFS       = 16'h0044;
    localparam logic [ADDR_W-1:0] CTRL_OFS      = 16'h0050;
    localparam logic [ADDR_W-1:0] KBC_DATA_PORT = 16'h0060;
    localparam logic [ADDR_W-1:0] KBC_CMD_PORT  = 16'h0064;

    localparam int KBC_BIT  = 12;
    localparam int IRQ_BIT0 = 6;

    localparam logic [DATA_W-1:0] STS_MASK =
        (DATA_W'(1) << KBC_BIT) | (DATA_W'((1 << IRQ_PAIRS) - 1) << IRQ_BIT0);

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STS  = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                 kbc;
        logic [IRQ_PAIRS-1:0] irq;
    } act_evt_t;

    function automatic logic [DATA_W-1:0] evt_to_vec(input act_evt_t e);
        logic [DATA_W-1:0] v;
        v = '0;
        v[KBC_BIT] = e.kbc;
        v[IRQ_BIT0 +: IRQ_PAIRS] = e.irq;
        return v;
    endfunction

endpackage

// File: rtl/pm_act_kbc_trap.sv
module pm_act_kbc_trap
    import pm_act_pkg::*;
#(
    parameter int              AW     = ADDR_W,
    parameter logic [AW-1:0]   PORT_A = KBC_DATA_PORT,
    parameter logic [AW-1:0]   PORT_B = KBC_CMD_PORT
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    output logic          hit
);

    logic addr_match;

    assign addr_match = (io_addr == PORT_A) || (io_addr == PORT_B);
    assign hit        = (io_rd || io_wr) && addr_match;

endmodule

// File: rtl/pm_act_irq_pairs.sv
module pm_act_irq_pairs
    import pm_act_pkg::*;
#(
    parameter int PAIRS = IRQ_PAIRS,
    localparam int LINES = 2 * PAIRS
) (
    input  logic [LINES-1:0] irq_n,
    output logic [PAIRS-1:0] pair_act
);

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign pair_act[k] = ~irq_n[k] | ~irq_n[k + PAIRS];
    end

endmodule

// File: rtl/pm_act_decode.sv
module pm_act_decode
    import pm_act_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] pm_base,
    input  logic [AW-1:0] reg_addr,
    output reg_sel_e      sel
);

    logic [AW-1:0] sts_addr;
    logic [AW-1:0] ctrl_addr;

    assign sts_addr  = pm_base + AW'(STS_OFS);
    assign ctrl_addr = pm_base + AW'(CTRL_OFS);

    always_comb begin
        if (reg_addr == sts_addr)       sel = SEL_STS;
        else if (reg_addr == ctrl_addr) sel = SEL_CTRL;
        else                            sel = SEL_NONE;
    end

endmodule

// File: rtl/pm_act_sts_reg.sv
module pm_act_sts_reg
    import pm_act_pkg::*;
#(
    parameter int             DW   = DATA_W,
    parameter logic [DW-1:0]  MASK = STS_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] sts_q
);

    logic [DW-1:0] sts_d;

    // Set has priority over clear so no activity is dropped.
    assign sts_d = ((sts_q & ~clr_vec) | set_vec) & MASK;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_d;
    end

    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(sts_q & ~clr_vec)) == $past(sts_q & ~clr_vec)));

    a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(set_vec & MASK)) == $past(set_vec & MASK)));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~MASK) == '0);

endmodule

// File: rtl/pm_activity_regs.sv
module pm_activity_regs
    import pm_act_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    pm_base,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_rd,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [IRQ_LINES-1:0] irq_n
);

    logic                 kbc_hit;
    logic [IRQ_PAIRS-1:0] pair_act;
    reg_sel_e             sel;
    act_evt_t             evt;
    logic [DATA_W-1:0]    set_vec;
    logic [DATA_W-1:0]    clr_vec;
    logic [DATA_W-1:0]    sts_q;
    logic                 scratch_q;

    pm_act_kbc_trap #(.AW(ADDR_W)) u_trap (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .hit     (kbc_hit)
    );

    pm_act_irq_pairs #(.PAIRS(IRQ_PAIRS)) u_irq (
        .irq_n    (irq_n),
        .pair_act (pair_act)
    );

    pm_act_decode #(.AW(ADDR_W)) u_dec (
        .pm_base  (pm_base),
        .reg_addr (reg_addr),
        .sel      (sel)
    );

    assign evt.kbc = kbc_hit;
    assign evt.irq = pair_act;
    assign set_vec = evt_to_vec(evt);
    assign clr_vec = (reg_wr && sel == SEL_STS) ? reg_wdata : '0;

    pm_act_sts_reg #(.DW(DATA_W), .MASK(STS_MASK)) u_sts (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .sts_q   (sts_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                          scratch_q <= 1'b0;
        else if (reg_wr && sel == SEL_CTRL) scratch_q <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                SEL_STS:  reg_rdata = sts_q;
                SEL_CTRL: reg_rdata = DATA_W'(scratch_q);
                default:  reg_rdata = '0;
            endcase
        end
    end

    a_r2_kbc_trap: assert property (@(posedge clk) disable iff (rst)
        kbc_hit |=> sts_q[KBC_BIT]);

    a_r9_scratch_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_CTRL) |=> (scratch_q == $past(reg_wdata[0])));

    a_r9_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel == SEL_CTRL) |-> (reg_rdata[DATA_W-1:1] == '0));

    a_r10_quiet_read: assert property (@(posedge clk) disable iff (rst)
        (!reg_rd || sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/pm_activity_regs_test.sv
module pm_activity_regs_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pm_base;
    logic [15:0] reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic        reg_rd;
    logic [15:0] reg_rdata;
    logic [15:0] io_addr;
    logic        io_rd;
    logic        io_wr;
    logic [7:0]  irq_n;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [15:0] m_sts  = 16'h0000;
    logic        m_ctrl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_activity_regs uut (
        .clk(clk), .rst(rst), .pm_base(pm_base), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .irq_n(irq_n)
    );

    function automatic logic [15:0] model_read();
        if (!reg_rd) return 16'h0000;
        if (reg_addr == 16'(pm_base + 16'h0044)) return m_sts & 16'h13C0;
        if (reg_addr == 16'(pm_base + 16'h0050)) return {15'h0, m_ctrl};
        return 16'h0000;
    endfunction

    task automatic step(input string tag);
        logic [15:0] exp_v;
        logic [15:0] nxt;
        logic [15:0] setb;
        logic [15:0] clrb;
        logic        nctrl;
        #1;
        exp_v = model_read();
        vectors++;
        if (reg_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: reg_rdata=%h expected=%h (addr=%h rd=%0d)",
                     tag, reg_rdata, exp_v, reg_addr, reg_rd);
        end
        setb = 16'h0000;
        if ((io_rd || io_wr) && (io_addr == 16'h0060 || io_addr == 16'h0064))
            setb[12] = 1'b1;
        for (int k = 0; k < 4; k++)
            if (!irq_n[k] || !irq_n[k+4]) setb[6+k] = 1'b1;
        clrb  = (reg_wr && reg_addr == 16'(pm_base + 16'h0044)) ? reg_wdata : 16'h0000;
        nctrl = (reg_wr && reg_addr == 16'(pm_base + 16'h0050)) ? reg_wdata[0] : m_ctrl;
        nxt   = ((m_sts & ~clrb) | setb) & 16'h13C0;
        @(posedge clk);
        if (rst) begin
            m_sts  = 16'h0000;
            m_ctrl = 1'b0;
        end else begin
            m_sts  = nxt;
            m_ctrl = nctrl;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_wdata = 16'h0; reg_addr = 16'h0;
        io_rd = 0; io_wr = 0; io_addr = 16'h0; irq_n = 8'hFF;
    endtask

    task automatic rd(input logic [15:0] ofs, input string tag);
        idle(); reg_rd = 1; reg_addr = 16'(pm_base + ofs); step(tag);
    endtask

    task automatic wr(input logic [15:0] ofs, input logic [15:0] d, input string tag);
        idle(); reg_wr = 1; reg_addr = 16'(pm_base + ofs); reg_wdata = d; step(tag);
    endtask

    task automatic io(input logic [15:0] a, input bit is_wr, input string tag);
        idle(); io_addr = a; io_rd = !is_wr; io_wr = is_wr; step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        idle();
        pm_base = 16'h0400;
        rst = 1;
        @(negedge clk);
        io_rd = 1; io_addr = 16'h0060; irq_n = 8'h00; step("R1");
        rd(16'h0044, "R1");
        rd(16'h0050, "R1");
        rst = 0;
        rd(16'h0044, "R1");
        rd(16'h0050, "R1");

        // R2: trap on read and on write cycles
        io(16'h0060, 0, "R2");
        rd(16'h0044, "R2");
        wr(16'h0044, 16'h1000, "R6");
        rd(16'h0044, "R6");
        io(16'h0064, 1, "R2");
        rd(16'h0044, "R2");
        wr(16'h0044, 16'hFFFF, "R6");

        // R3: near-miss addresses and idle strobes
        io(16'h0061, 0, "R3");
        io(16'h0063, 1, "R3");
        io(16'h0065, 0, "R3");
        io(16'h1060, 1, "R3");
        idle(); io_addr = 16'h0060; step("R3");
        rd(16'h0044, "R3");

        // R4: each interrupt line alone
        for (int k = 0; k < 8; k++) begin
            wr(16'h0044, 16'hFFFF, "R4");
            idle(); irq_n = ~(8'h01 << k); step("R4");
            rd(16'h0044, "R4");
        end

        // R5: sticky across idle cycles
        wr(16'h0044, 16'hFFFF, "R5");
        idle(); irq_n = 8'hFE; step("R5");
        for (int i = 0; i < 5; i++) rd(16'h0044, "R5");

        // R6: writing 0 keeps the bit
        wr(16'h0044, 16'h0000, "R6");
        wr(16'h0044, 16'hEFBF, "R6");
        rd(16'h0044, "R6");

        // R7: set and clear at the same edge
        idle(); reg_wr = 1; reg_addr = 16'(pm_base + 16'h0044);
        reg_wdata = 16'h0040; irq_n = 8'hEF; step("R7");
        rd(16'h0044, "R7");
        idle(); reg_wr = 1; reg_addr = 16'(pm_base + 16'h0044);
        reg_wdata = 16'h1000; io_rd = 1; io_addr = 16'h0064; step("R7");
        rd(16'h0044, "R7");

        // R8: reserved bits
        wr(16'h0044, 16'hFFFF, "R8");
        idle(); irq_n = 8'h00; io_wr = 1; io_addr = 16'h0060; step("R8");
        rd(16'h0044, "R8");
        wr(16'h0044, 16'h2C3F, "R8");
        rd(16'h0044, "R8");

        // R9: scratchpad
        wr(16'h0050, 16'hFFFF, "R9");
        rd(16'h0050, "R9");
        wr(16'h0050, 16'hFFFE, "R9");
        rd(16'h0050, "R9");
        wr(16'h0050, 16'h0001, "R9");

        // R10: other offsets and idle strobe
        rd(16'h0046, "R10");
        rd(16'h0040, "R10");
        rd(16'h0051, "R10");
        wr(16'h0046, 16'hFFFF, "R10");
        wr(16'h004C, 16'hFFFF, "R10");
        idle(); reg_addr = 16'(pm_base + 16'h0044); step("R10");
        rd(16'h0044, "R10");
        rd(16'h0050, "R10");

        // R11: base relocation
        idle(); reg_rd = 1; reg_addr = 16'h0444; pm_base = 16'h1000; step("R11");
        rd(16'h0044, "R11");
        rd(16'h0050, "R11");
        wr(16'h0044, 16'hFFFF, "R11");
        rd(16'h0044, "R11");

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            idle();
            reg_rd    = ($urandom_range(0, 3) != 0);
            reg_wr    = ($urandom_range(0, 5) == 0);
            reg_wdata = 16'($urandom);
            case ($urandom_range(0, 3))
                0: reg_addr = 16'(pm_base + 16'h0044);
                1: reg_addr = 16'(pm_base + 16'h0050);
                2: reg_addr = 16'(pm_base + 16'($urandom_range(0, 127)));
                default: reg_addr = 16'($urandom);
            endcase
            io_rd   = ($urandom_range(0, 3) == 0);
            io_wr   = ($urandom_range(0, 3) == 0);
            io_addr = 16'h0060 + 16'($urandom_range(0, 5));
            for (int k = 0; k < 8; k++)
                irq_n[k] = ($urandom_range(0, 15) != 0);
            step("R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule